// File: doc/BRIEF.md
# Frequent Value Bus Decoder

This block sits at the receiving end of a low-switching data bus. The sender replaces values it has seen often with one-hot pointers into a small value table. Each word it sends is XORed with the word it sent before, and an unchanged bus word means "same value as last time". The decoder undoes both steps. It XORs each received bus word with the previous bus word to recover a code. A zero code repeats the last output. A one-hot code reads the matching table entry. Any other code, or any code that arrives with the skip flag, is the data value itself.

No table contents ever cross the bus, so the decoder keeps its own copy of the sender's table. It changes that copy with exactly the same rules as the sender: the same insertion, the same victim choice, the same reference-bit marking and the same ageing interval. Entry 0 always holds zero. Small values from 1 up to a parameter limit are never stored. One value is accepted per cycle on `in_valid`, and the result appears one cycle later with `out_valid`.

Top module: `fv_bus_decoder`

## Requirements
- R1: The code for each accepted word is `bus_word` XOR the previously accepted bus word, and that previous word is 0 after reset.
- R2: A zero code makes the output repeat the last produced value, and the table is left unchanged.
- R3: A code with exactly one bit set, with `skip_dec` low, outputs the value stored in the entry whose index is that bit's position (bit k selects entry k).
- R4: A code with more than one bit set, or any nonzero code with `skip_dec` high, is output unchanged as the data value.
- R5: A raw value in the range 1..EXCL_HI (16 by default) is never written into the table.
- R6: Entry 0 always holds zero, so a code of 1 (bit 0 set) with `skip_dec` low always outputs 0.
- R7: A raw value that is not excluded is written into the lowest-indexed entry from 1 upward whose reference bit is 0 and whose age stamp is 0. That entry then gets reference bit 1 and age 0. When no entry qualifies, nothing is written.
- R8: A one-hot hit on entry k (k above 0) sets the reference bit of entry k.
- R9: Every accepted word, repeats included, advances an interval counter. The INTERVAL-th word (16 by default) ages all entries: each age stamp shifts right with the reference bit entering at the top, and all reference bits clear. This happens after that word's own table update.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_data` changes only in those cycles.
- R11: After reset `out_valid` is 0, `out_data` is 0, and every entry above 0 is empty, with value 0, reference bit 0 and age 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A bus word is present this cycle |
| bus_word | input | WIDTH | Word received from the bus |
| skip_dec | input | 1 | Sender marks the word as raw even if its code is one-hot |
| out_valid | output | 1 | Recovered value valid, one cycle after `in_valid` |
| out_data | output | WIDTH | Recovered data value, held between words |

## Verification
A wrong victim choice, a missed reference bit or an ageing tick one word early does not show at the ports right away. It shows later, when the sender points at an entry that the decoder has filled differently, and the output is then some other stored value. The bench therefore runs its own model of the sender's table and sends thousands of mixed values through it: repeats, excluded small values, one-hot raw values and a pool larger than the table. Every output is compared with the value that was sent, so any drift between the tables appears at the first hit on an entry that differs. Directed cases check the repeat, the zero entry, skip handling and exclusion at the first word where each one matters.

// File: rtl/fv_bus_decoder.sv
module fv_bus_decoder #(
  parameter int WIDTH    = 32,
  parameter int TS_W     = 3,
  parameter int INTERVAL = 16,
  parameter int EXCL_HI  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] bus_word,
  input  logic             skip_dec,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  localparam int NENT  = WIDTH;
  localparam int IDX_W = $clog2(NENT);
  localparam int CNT_W = $clog2(INTERVAL + 1);

  logic [WIDTH-1:0]            prev_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [NENT-1:0][WIDTH-1:0]  val_q, val_n;
  logic [NENT-1:0][TS_W-1:0]   ts_q, ts_n;
  logic [NENT-1:0]             ref_q, ref_n;

  logic [WIDTH-1:0] code;
  logic             is_zero, is_hot, is_raw, excluded, tick;
  logic [IDX_W-1:0] hit_idx, vic_idx;
  logic             vic_ok;
  logic [WIDTH-1:0] next_out;

  assign code     = bus_word ^ prev_q;
  assign is_zero  = (code == '0);
  assign is_hot   = $onehot(code) && !skip_dec;
  assign is_raw   = !is_zero && !is_hot;
  assign excluded = (code >= WIDTH'(1)) && (code <= WIDTH'(EXCL_HI));
  assign tick     = in_valid && (cnt_q == CNT_W'(INTERVAL - 1));

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NENT; i++)
      if (code[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    vic_idx = '0;
    vic_ok  = 1'b0;
    for (int i = NENT - 1; i >= 1; i--)
      if (!ref_q[i] && ts_q[i] == '0) begin
        vic_idx = IDX_W'(i);
        vic_ok  = 1'b1;
      end
  end

  assign next_out = is_zero ? out_data : (is_hot ? val_q[hit_idx] : code);

  always_comb begin
    val_n = val_q;
    ref_n = ref_q;
    ts_n  = ts_q;
    if (in_valid) begin
      if (is_hot && hit_idx != '0)
        ref_n[hit_idx] = 1'b1;
      if (is_raw && !excluded && vic_ok) begin
        val_n[vic_idx] = code;
        ref_n[vic_idx] = 1'b1;
        ts_n[vic_idx]  = '0;
      end
    end
    if (tick) begin
      for (int i = 0; i < NENT; i++)
        ts_n[i] = {ref_n[i], ts_n[i][TS_W-1:1]};
      ref_n = '0;
    end
    val_n[0] = '0;
    ref_n[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      cnt_q     <= '0;
      val_q     <= '0;
      ref_q     <= '0;
      ts_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      val_q     <= val_n;
      ref_q     <= ref_n;
      ts_q      <= ts_n;
      if (in_valid) begin
        prev_q   <= bus_word;
        out_data <= next_out;
        cnt_q    <= tick ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fv_bus_decoder_chk.sv
module fv_bus_decoder_chk #(
  parameter int WIDTH    = 32,
  parameter int INTERVAL = 16,
  parameter int EXCL_HI  = 16,
  parameter int CNT_W    = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic [WIDTH-1:0]              bus_word,
  input logic                          skip_dec,
  input logic                          out_valid,
  input logic [WIDTH-1:0]              out_data,
  input logic [WIDTH-1:0]              prev_q,
  input logic [CNT_W-1:0]              cnt_q,
  input logic [WIDTH-1:0]              ref_q,
  input logic [WIDTH-1:0][WIDTH-1:0]   val_q
);
  logic small_stored;
  always_comb begin
    small_stored = 1'b0;
    for (int i = 1; i < WIDTH; i++)
      if (val_q[i] >= WIDTH'(1) && val_q[i] <= WIDTH'(EXCL_HI)) small_stored = 1'b1;
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  assert_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bus_word == prev_q) |=> $stable(out_data));
  assert_zero_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !skip_dec && (bus_word ^ prev_q) == WIDTH'(1)) |=> out_data == '0);
  assert_skip_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && skip_dec && bus_word != prev_q) |=> out_data == $past(bus_word ^ prev_q));
  assert_no_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !small_stored);
  assert_age_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_q == CNT_W'(INTERVAL - 1)) |=> ref_q == '0);
endmodule

bind fv_bus_decoder fv_bus_decoder_chk #(
  .WIDTH(WIDTH), .INTERVAL(INTERVAL), .EXCL_HI(EXCL_HI), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bus_word(bus_word),
  .skip_dec(skip_dec), .out_valid(out_valid), .out_data(out_data),
  .prev_q(prev_q), .cnt_q(cnt_q), .ref_q(ref_q), .val_q(val_q)
);

// File: tb/fv_bus_decoder_bench.sv
module fv_bus_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] bus_word = '0;
  logic        skip_dec = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mval [32];
  bit          mref [32];
  logic [2:0]  mts  [32];
  int          mcnt;
  logic [31:0] mprev, mlast;

  always #(CLK_PERIOD/2) clk = ~clk;

  fv_bus_decoder u_fv_bus_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bus_word(bus_word),
    .skip_dec(skip_dec), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      mval[i] = '0; mref[i] = 1'b0; mts[i] = '0;
    end
    mcnt = 0; mprev = '0; mlast = '0;
  endtask

  // sender model: same table rules as the decoder must follow
  task automatic encode(input logic [31:0] v, output logic [31:0] bw, output logic sk);
    logic [31:0] code;
    int hit;
    sk = 1'b0;
    if (v == mlast) code = '0;
    else begin
      hit = -1;
      for (int i = 31; i >= 0; i--) if (mval[i] == v) hit = i;
      if (hit >= 0) begin
        code = 32'd1 << hit;
        if (hit != 0) mref[hit] = 1'b1;
      end else begin
        code = v;
        sk = $onehot(v);
        if (!(v >= 32'd1 && v <= 32'd16)) begin
          int vic;
          vic = -1;
          for (int i = 31; i >= 1; i--) if (!mref[i] && mts[i] == 3'd0) vic = i;
          if (vic > 0) begin
            mval[vic] = v; mref[vic] = 1'b1; mts[vic] = '0;
          end
        end
      end
    end
    mcnt++;
    if (mcnt == 16) begin
      mcnt = 0;
      for (int i = 0; i < 32; i++) begin
        mts[i] = {mref[i], mts[i][2:1]};
        mref[i] = 1'b0;
      end
    end
    bw = code ^ mprev;
    mprev = bw;
    mlast = v;
  endtask

  task automatic send(input logic [31:0] v, input string req);
    logic [31:0] bw;
    logic sk;
    encode(v, bw, sk);
    bus_word = bw; skip_dec = sk; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, out_data, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pool_val(input int k);
    return (32'h9E37_79B9 * (k + 3)) | 32'h0100_0000;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    check("R11 reset valid", {31'd0, out_valid}, 32'd0);
    check("R11 reset data", out_data, 32'd0);

    send(32'h0000_0000, "R2 zero after reset repeats 0");
    send(32'h0000_0005, "R4 raw multi-bit");
    send(32'hDEAD_BEEF, "R4 raw insert R7");
    send(32'hDEAD_BEEF, "R2 repeat");
    @(negedge clk);
    check("R10 idle valid", {31'd0, out_valid}, 32'd0);
    check("R10 idle hold", out_data, 32'hDEAD_BEEF);
    send(32'h0000_0000, "R6 entry 0");
    send(32'hDEAD_BEEF, "R3 hit entry1 R5 not small");
    send(32'h0000_0100, "R4 skip one-hot raw");
    send(32'h1234_5678, "R7 next victim");
    send(32'h0000_0100, "R3 hit one-hot stored R8");
    send(32'h0000_0008, "R4 skip excluded one-hot R5");
    send(32'h1234_5678, "R3 hit R1");

    do_reset();
    check("R11 reset clears", out_data, 32'd0);
    for (int k = 0; k < 40; k++) send(pool_val(k), "R7 fill no victim");
    for (int k = 0; k < 40; k++) send(pool_val(k), "R9 aged reuse");

    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [31:0] v;
      r = $urandom % 100;
      if (r < 12) v = mlast;
      else if (r < 25) v = $urandom % 21;
      else if (r < 35) v = 32'd1 << ($urandom % 32);
      else v = pool_val($urandom % 48);
      send(v, "R3 R4 R8 R9 random");
      if ($urandom % 8 == 0) begin
        @(negedge clk);
        check("R10 random hold", out_data, v);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule